// File: doc/BRIEF.md
# Selected-Cell Bit Harvester and Packer

This block sits between a page reader and a hash-based conditioner in an entropy path. A page arrives as a stream of data words, and the first word of each page carries a start flag. Alongside it comes a list of bit offsets. Each offset names one usable cell of the current page. The list for a page is in ascending order, and its last entry carries an end flag. The block picks out only the bits at the listed offsets and discards everything else in the page.

The picked bits are packed into fixed-size blocks of `BLK_BITS` bits (512 by default, the input block of the downstream hash). A block fills across as many pages as it takes. A full block is handed over through a valid/ready handshake. Harvesting goes on into the next block while a finished block waits, until the accumulator is full as well. A page-request output tells the sequencer when another page is wanted.

An offset that is not above the previous offset of the same page is dropped, and a one-cycle error pulse is raised.

Top module: `cell_bit_harvester`

## Requirements
- R1: Only the bit at each listed offset is harvested. Offset `o` selects bit `o % WORD_W` of word `o / WORD_W` of the current page, with word 0 being the word marked as page start. No other page bit reaches an output block.
- R2: Bit k of an output block (k = 0 is the LSB) is the k-th bit harvested for that block, in list order.
- R3: `blk_valid` rises only once `BLK_BITS` bits have been gathered. The number of blocks delivered equals the number of harvested bits divided by `BLK_BITS`, rounded down.
- R4: A partly filled block is kept from one page to the next, and the page boundaries leave no gap in the bit sequence.
- R5: When a block fills in the middle of a page, the rest of that page's harvested bits start the next block and none is lost.
- R6: While `blk_valid` is high and `blk_ready` is low, `blk_valid` stays high and `blk_data` stays unchanged. Harvesting pauses only while the accumulator is full and the output is occupied.
- R7: `pg_req` is low whenever `blk_valid` is high. It is high whenever neither the accumulator nor the output holds a full block.
- R8: A list entry whose offset is less than or equal to the previous entry of the same page is consumed without being harvested. `err_order` is then high for exactly one cycle, on the cycle after that entry is taken.
- R9: After the entry with `loc_last` has been taken, the remaining words of that page are accepted and discarded. The next word with `dat_first` set begins a new page at word index 0.
- R10: During reset and right after it, `blk_valid` and `err_order` are 0, while `pg_req` and `dat_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dat_valid | input | 1 | Page word available |
| dat_first | input | 1 | Word is the first of a page |
| dat_word | input | WORD_W | Page data word |
| dat_ready | output | 1 | Page word accepted this cycle when valid |
| loc_valid | input | 1 | Offset entry available |
| loc_ofs | input | OFS_W | Bit offset within the page |
| loc_last | input | 1 | Entry is the last one for the page |
| loc_ready | output | 1 | Offset entry consumed this cycle when valid |
| blk_valid | output | 1 | Full block available |
| blk_ready | input | 1 | Downstream takes the block |
| blk_data | output | BLK_BITS | Packed block, first harvested bit in bit 0 |
| pg_req | output | 1 | Another page is wanted |
| err_order | output | 1 | One-cycle pulse for an out-of-order offset |

## Verification
A harvested bit enters the accumulator at the rising edge that ends the cycle in which its entry is consumed. A full accumulator moves into the output register one edge later if the output is free, so `blk_valid` rises two edges after the last bit's entry is taken. `err_order` follows a dropped entry by exactly one edge. `pg_req`, `dat_ready` and `loc_ready` come from registered state without further delay. The bench drives inputs at the falling edge and samples every output 1 ns before the next rising edge. Because the handshake outcome of an edge is known at that moment, each block is compared at the edge where it is taken, and the stall hold is checked on the sample that follows.

// File: rtl/chb_pkg.sv
package chb_pkg;
  // Verdict on the offset entry at the head of the list for this cycle
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,  // wait: no word held, page done, or accumulator full
    ACT_TAKE = 2'd1,  // offset lies in the held word: harvest and consume
    ACT_DROP = 2'd2,  // offset out of order: consume without harvest
    ACT_SKIP = 2'd3   // offset lies in a later word: release the held word
  } loc_act_e;
endpackage

// File: rtl/chb_word_slot.sv
module chb_word_slot #(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic              release_i,
  input  logic              done_set,
  output logic              held,
  output logic [WORD_W-1:0] word,
  output logic [IDX_W-1:0]  idx,
  output logic              done
);
  logic              held_q, held_d;
  logic              done_q, done_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q;
  logic              cap;

  assign in_ready = !held_q || release_i;
  assign cap      = in_valid && in_ready;

  always_comb begin
    held_d = held_q;
    idx_d  = idx_q;
    done_d = done_q;
    if (done_set) done_d = 1'b1;
    if (cap) begin
      held_d = 1'b1;
      idx_d  = in_first ? '0 : idx_q + IDX_W'(1);
      if (in_first) done_d = 1'b0;
    end else if (release_i) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      held_q <= held_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) word_q <= in_word;
  end

  assign held = held_q;
  assign word = word_q;
  assign idx  = idx_q;
  assign done = done_q;

  // R1
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && !release_i |=> held_q && $stable(word_q) && $stable(idx_q));
endmodule

// File: rtl/chb_order_check.sv
module chb_order_check #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] ofs,
  input  logic             stale,
  input  logic             consume,
  input  logic             consume_last,
  output logic             bad,
  output logic             err_pulse
);
  logic             have_q, have_d;
  logic [OFS_W-1:0] prev_q;
  logic             prev_en;
  logic             err_q;

  assign bad = stale || (have_q && (ofs <= prev_q));

  always_comb begin
    have_d  = have_q;
    prev_en = 1'b0;
    if (consume) begin
      if (consume_last) begin
        have_d = 1'b0;
      end else if (!bad) begin
        have_d  = 1'b1;
        prev_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      have_q <= have_d;
      err_q  <= consume && bad;
    end
  end

  always_ff @(posedge clk) begin
    if (prev_en) prev_q <= ofs;
  end

  assign err_pulse = err_q;

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q || $past(consume));
endmodule

// File: rtl/chb_block_packer.sv
module chb_block_packer #(
  parameter int BLK_BITS = 512,
  localparam int CNT_W = $clog2(BLK_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic                bit_in,
  input  logic                blk_ready,
  output logic                acc_full,
  output logic                blk_valid,
  output logic [BLK_BITS-1:0] blk_data
);
  logic [BLK_BITS-1:0] acc_q, acc_d;
  logic [BLK_BITS-1:0] out_q;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                out_v_q, out_v_d;
  logic                xfer;

  assign acc_full = (cnt_q == CNT_W'(BLK_BITS));

  always_comb begin
    xfer    = acc_full && (!out_v_q || blk_ready);
    acc_d   = {bit_in, acc_q[BLK_BITS-1:1]};
    cnt_d   = cnt_q;
    out_v_d = out_v_q;
    if (xfer)      cnt_d = '0;
    else if (push) cnt_d = cnt_q + CNT_W'(1);
    if (xfer)           out_v_d = 1'b1;
    else if (blk_ready) out_v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      out_v_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      out_v_q <= out_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) acc_q <= acc_d;
  end

  always_ff @(posedge clk) begin
    if (xfer) out_q <= acc_q;
  end

  assign blk_valid = out_v_q;
  assign blk_data  = out_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BLK_BITS));
  // R6
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_v_q && !blk_ready |=> out_v_q && $stable(out_q));
  // R6
  push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !acc_full);
endmodule

// File: rtl/cell_bit_harvester.sv
module cell_bit_harvester
  import chb_pkg::*;
#(
  parameter int WORD_W     = 64,
  parameter int PAGE_WORDS = 1024,
  parameter int BLK_BITS   = 512,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int IDX_W = $clog2(PAGE_WORDS),
  localparam int OFS_W = BIT_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dat_valid,
  input  logic                dat_first,
  input  logic [WORD_W-1:0]   dat_word,
  output logic                dat_ready,
  input  logic                loc_valid,
  input  logic [OFS_W-1:0]    loc_ofs,
  input  logic                loc_last,
  output logic                loc_ready,
  output logic                blk_valid,
  input  logic                blk_ready,
  output logic [BLK_BITS-1:0] blk_data,
  output logic                pg_req,
  output logic                err_order
);
  logic [1:0]        rs_q;
  logic              arst_n;
  logic              held, done, acc_full, bad, stale;
  logic              release_w, push, done_set;
  logic [WORD_W-1:0] word;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  loc_word;
  logic [BIT_W-1:0]  loc_bit;
  loc_act_e          act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  assign loc_word = loc_ofs[OFS_W-1:BIT_W];
  assign loc_bit  = loc_ofs[BIT_W-1:0];
  assign stale    = loc_word < idx;

  always_comb begin
    act = ACT_IDLE;
    if (held && !done && loc_valid) begin
      if (bad)                  act = ACT_DROP;
      else if (loc_word == idx) act = acc_full ? ACT_IDLE : ACT_TAKE;
      else                      act = ACT_SKIP;
    end
  end

  assign loc_ready = (act == ACT_TAKE) || (act == ACT_DROP);
  assign push      = (act == ACT_TAKE);
  assign done_set  = loc_ready && loc_valid && loc_last;
  assign release_w = held && (done || (act == ACT_SKIP));
  assign pg_req    = !acc_full && !blk_valid;

  chb_word_slot #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_slot (
    .clk(clk), .rst_n(arst_n),
    .in_valid(dat_valid), .in_first(dat_first), .in_word(dat_word),
    .in_ready(dat_ready), .release_i(release_w), .done_set(done_set),
    .held(held), .word(word), .idx(idx), .done(done)
  );

  chb_order_check #(.OFS_W(OFS_W)) i_order (
    .clk(clk), .rst_n(arst_n),
    .ofs(loc_ofs), .stale(stale),
    .consume(loc_ready && loc_valid), .consume_last(loc_last),
    .bad(bad), .err_pulse(err_order)
  );

  chb_block_packer #(.BLK_BITS(BLK_BITS)) i_pack (
    .clk(clk), .rst_n(arst_n),
    .push(push), .bit_in(word[loc_bit]), .blk_ready(blk_ready),
    .acc_full(acc_full), .blk_valid(blk_valid), .blk_data(blk_data)
  );

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    blk_valid |-> !pg_req);
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
    err_order |-> $past(loc_valid && loc_ready));
  // R9
  page_skip_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $past(done_set) && held |-> !loc_ready);
endmodule

// File: tb/test_cell_bit_harvester.sv
module test_cell_bit_harvester;
  localparam int WW = 8, PW = 4, BB = 16, OW = 5, NP = 36, ME = 40;

  logic clk, rst_n;
  logic dat_valid, dat_first, dat_ready;
  logic [WW-1:0] dat_word;
  logic loc_valid, loc_last, loc_ready;
  logic [OW-1:0] loc_ofs;
  logic blk_valid, blk_ready, pg_req, err_order;
  logic [BB-1:0] blk_data;

  cell_bit_harvester #(.WORD_W(WW), .PAGE_WORDS(PW), .BLK_BITS(BB)) i_cell_bit_harvester (
    .clk(clk), .rst_n(rst_n),
    .dat_valid(dat_valid), .dat_first(dat_first), .dat_word(dat_word), .dat_ready(dat_ready),
    .loc_valid(loc_valid), .loc_ofs(loc_ofs), .loc_last(loc_last), .loc_ready(loc_ready),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
    .pg_req(pg_req), .err_order(err_order)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int lofs [NP][ME];
  bit lbad [NP][ME];
  int ln [NP];
  logic [WW-1:0] pdat [NP][PW];
  bit exp_bits [0:2047];
  int exp_n = 0, blocks_seen = 0, err_seen = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic add(input int p, input int o, input bit b);
    lofs[p][ln[p]] = o;
    lbad[p][ln[p]] = b;
    ln[p]++;
  endtask

  task automatic build();
    for (int p = 0; p < NP; p++) begin
      ln[p] = 0;
      for (int w = 0; w < PW; w++) pdat[p][w] = 8'((p*53 + w*29 + 7) ^ (p*w*3));
      case (p % 6)
        0: add(p, (p*7) % 32, 0);
        1: for (int o = 0; o < 32; o++) add(p, o, 0);
        2: for (int o = p % 3; o < 32; o += 3) add(p, o, 0);
        3: for (int o = 0; o < 8; o += 2) add(p, o, 0);
        4: for (int o = 1; o < 32; o += 5) begin
             add(p, o, 0);
             if (p == 4 && o == 6) add(p, 6, 1);   // duplicate offset
             if (p == 10 && o == 11) add(p, 3, 1); // smaller offset
           end
        default: for (int o = 24; o < 32; o += 3) add(p, o, 0);
      endcase
      if (p == 16) add(p, 0, 1);                   // out-of-order last entry
      for (int i = 0; i < ln[p]; i++)
        if (!lbad[p][i]) begin
          exp_bits[exp_n] = pdat[p][lofs[p][i] / WW][lofs[p][i] % WW];
          exp_n++;
        end
    end
  endtask

  // page data driver
  task automatic drive_pages();
    for (int p = 0; p < NP; p++)
      for (int w = 0; w < PW; w++) begin
        bit acc;
        acc = 0;
        while (!acc) begin
          @(negedge clk);
          dat_valid = 1'b1; dat_first = (w == 0); dat_word = pdat[p][w];
          #4 acc = dat_ready;
          @(posedge clk);
        end
      end
    @(negedge clk) dat_valid = 1'b0;
  endtask

  // offset list driver
  task automatic drive_locs();
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < ln[p]; i++) begin
        bit acc;
        acc = 0;
        while (!acc) begin
          @(negedge clk);
          loc_valid = 1'b1; loc_ofs = OW'(lofs[p][i]); loc_last = (i == ln[p]-1);
          #4 acc = loc_ready;
          @(posedge clk);
        end
      end
    @(negedge clk) loc_valid = 1'b0;
  endtask

  // block consumer and port monitor
  initial begin
    int cyc;
    bit pv, pr;
    logic [BB-1:0] pd;
    cyc = 0; pv = 0; pr = 0; pd = '0;
    blk_ready = 1'b0;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      cyc++;
      blk_ready = (cyc % 3 != 2) && ((cyc / 16) % 4 != 3);
      #4;
      if (err_order) err_seen++;
      if (blk_valid) chk(!pg_req, "R7 pg_req while block waits", 64'(pg_req), 64'd0);
      if (pv && !pr) begin
        chk(blk_valid == 1'b1, "R6 valid held under stall", 64'(blk_valid), 64'd1);
        chk(blk_data == pd, "R6 data held under stall", 64'(blk_data), 64'(pd));
      end
      if (blk_valid && blk_ready) begin
        logic [BB-1:0] e;
        e = '0;
        for (int k = 0; k < BB; k++)
          if (blocks_seen*BB + k < exp_n) e[k] = exp_bits[blocks_seen*BB + k];
        // R1 R2 R4 R5 R9: selected bits, LSB-first, across and inside pages
        chk(blocks_seen*BB + BB <= exp_n && blk_data == e, "R1 R2 R4 R5 R9 block content",
            64'(blk_data), 64'(e));
        blocks_seen++;
      end
      pv = blk_valid; pr = blk_ready; pd = blk_data;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", blocks_seen, exp_n / BB);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    dat_valid = 0; dat_first = 0; dat_word = '0;
    loc_valid = 0; loc_last = 0; loc_ofs = '0;
    rst_n = 1'b0;
    build();
    repeat (4) @(posedge clk);
    #4;
    // R10 reset values
    chk(blk_valid == 1'b0, "R10 blk_valid in reset", 64'(blk_valid), 64'd0);
    chk(err_order == 1'b0, "R10 err_order in reset", 64'(err_order), 64'd0);
    chk(pg_req == 1'b1, "R10 pg_req in reset", 64'(pg_req), 64'd1);
    chk(dat_ready == 1'b1, "R10 dat_ready in reset", 64'(dat_ready), 64'd1);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #4;
    chk(pg_req == 1'b1 && blk_valid == 1'b0, "R10 state after release",
        64'({pg_req, blk_valid}), 64'h2);
    fork
      drive_pages();
      drive_locs();
    join
    wait (blocks_seen >= exp_n / BB);
    repeat (40) @(posedge clk);
    #4;
    // R3: block count equals harvested bits / BLK_BITS
    chk(blocks_seen == exp_n / BB, "R3 block count", 64'(blocks_seen), 64'(exp_n / BB));
    chk(blk_valid == 1'b0, "R3 no block from partial bits", 64'(blk_valid), 64'd0);
    // R8: three out-of-order entries injected
    chk(err_seen == 3, "R8 error pulses", 64'(err_seen), 64'd3);
    chk(pg_req == 1'b1, "R7 pg_req with partial block", 64'(pg_req), 64'd1);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule